// File: doc/BRIEF.md
# Serial Transmit-End and Status Flag Unit

This unit keeps three status flags for a serial port that runs either as a plain asynchronous transmitter or as a smart-card transmitter. The flags are transmit-data-empty, transmit-end and the received multiprocessor bit. It watches the strobes that the shifter, the baud generator and the receiver already produce. It also watches the CPU's read and write strobes on the status register. From these it decides when each flag sets, clears or holds, and it presents the flags as one status byte.

Software clears the empty flag in two steps, as a guard against stale handshakes. First, a status read has to find the empty flag set. The next status write then clears it by writing a zero to the empty-flag bit. That same clear also drops the transmit-end flag, which means a new transmission is under way.

In asynchronous mode, transmit-end rises when the last bit of a character goes out and no new data is waiting. In smart-card mode it rises only after a guard interval that is timed in half elementary-time-unit ticks, and the length of that interval depends on the guard-time select.

Top module: `sci_txend_status`

## Requirements
- R1: After reset, and on any cycle with standby asserted, transmit-end and transmit-empty read 1, the write arm is dropped and any pending guard interval is abandoned. Reset also sets the multiprocessor flag to 0; standby leaves it unchanged.
- R2: Status byte layout: bit 0 is transmit-empty, bit 1 is transmit-end, bit 2 is the multiprocessor flag, and bits 7..3 read 0. A status write changes no flag except through the clear described in R7. Writing 1 to bits 1 or 2 has no effect.
- R3: While transmit enable is 0, transmit-end is held at 1 in asynchronous mode. In smart-card mode it is held at 1 only while the error-signal flag is also 0.
- R4: In asynchronous mode, a last-bit strobe while transmit-empty is 1 sets transmit-end on the next cycle. When transmit-empty is 0, the strobe leaves transmit-end unchanged.
- R5: In smart-card mode, a last-bit strobe starts a guard interval of 5 half-unit ticks when guard select is 0, or 2 ticks when it is 1. Transmit-end becomes 1 in the cycle after the final tick, but only if transmit-empty is 1 and the error-signal flag is 0 in that tick's cycle. Otherwise the interval ends without setting it.
- R6: A new last-bit strobe restarts the guard interval from zero. A clear under R7 abandons a pending interval.
- R7: A status read arms the clear if transmit-empty is 1 at that read, and disarms it if transmit-empty is 0. The next status write consumes the arm. If that write is armed and its bit 0 is 0, transmit-empty and transmit-end both go to 0. An unarmed write leaves both unchanged.
- R8: A transfer strobe, meaning the shifter has taken the data, sets transmit-empty to 1 on the next cycle.
- R9: A capture strobe loads the received multiprocessor bit into the multiprocessor flag only when all three of these hold: receive enable is 1, multiprocessor format is on, and the port is in asynchronous mode.
- R10: While receive enable is 0, the multiprocessor flag holds its value regardless of capture strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby entry; acts as a flag reset |
| sc_mode_i | input | 1 | 1 selects smart-card mode |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| guard_sel_i | input | 1 | Guard-time select (0: 5 half ticks, 1: 2 half ticks) |
| err_sig_i | input | 1 | Error-signal flag from the receiver side |
| half_etu_i | input | 1 | One-cycle tick every half elementary time unit |
| last_bit_i | input | 1 | Last bit of a character is being sent |
| tx_xfer_i | input | 1 | Shifter accepted data; transmit-empty sets |
| mp_fmt_i | input | 1 | Multiprocessor format enabled |
| mp_bit_i | input | 1 | Received multiprocessor bit |
| mp_cap_i | input | 1 | Capture strobe for the multiprocessor bit |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status write data |
| stat_o | output | 8 | Status byte |
| tdre_o | output | 1 | Transmit-empty flag |
| tend_o | output | 1 | Transmit-end flag |
| mpb_o | output | 1 | Multiprocessor flag |

## Verification
The hardest situation to reach from the ports is a smart-card guard interval that ends at the exact tick count while transmit-empty is set and the error flag is clear. Reaching it needs a full clear handshake, a transfer and a last-bit strobe, in that order, followed by the right number of ticks. Directed sequences build this chain for both guard settings, and stop one tick short to confirm nothing happens early. They also cover a restart in mid-interval, a cancel by a clear, and an error-flag veto. Seeded random traffic then runs a long mix of reads, writes, ticks, strobes and mode changes, and it is compared every cycle against a reference model in the bench.

// File: rtl/sci_stat_pkg.sv
package sci_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int TDRE_BIT = 0;
    localparam int TEND_BIT = 1;
    localparam int MPB_BIT  = 2;

    typedef struct packed {
        logic mpb;
        logic tend;
        logic tdre;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{mpb: 1'b0, tend: 1'b1, tdre: 1'b1};

    typedef enum logic [1:0] {
        TEND_HOLD  = 2'd0,
        TEND_SET   = 2'd1,
        TEND_CLEAR = 2'd2
    } tend_act_e;

    function automatic logic [STAT_W-1:0] pack_status(flags_t f);
        logic [STAT_W-1:0] s;
        s           = '0;
        s[TDRE_BIT] = f.tdre;
        s[TEND_BIT] = f.tend;
        s[MPB_BIT]  = f.mpb;
        return s;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sci_clr_arm.sv
module sci_clr_arm (
    input  logic clk,
    input  logic rst,
    input  logic standby_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_zero_i,
    input  logic tdre_i,
    output logic clr_o
);
    logic armed_q;

    // a write consumes the arm; a read reloads it from the flag it saw
    always_ff @(posedge clk) begin
        if (rst || standby_i) begin
            armed_q <= 1'b0;
        end else if (wr_i) begin
            armed_q <= 1'b0;
        end else if (rd_i) begin
            armed_q <= tdre_i;
        end
    end

    assign clr_o = wr_i && armed_q && wr_zero_i && !standby_i;

endmodule

// File: rtl/sci_guard_timer.sv
module sci_guard_timer #(
    parameter int TICKS_GM0 = 5,
    parameter int TICKS_GM1 = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic abort_i,
    input  logic start_i,
    input  logic tick_i,
    input  logic gm_i,
    output logic fire_o
);
    localparam int MAXT  = sci_stat_pkg::max2(TICKS_GM0, TICKS_GM1);
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] LAST0 = CNT_W'(TICKS_GM0 - 1);
    localparam logic [CNT_W-1:0] LAST1 = CNT_W'(TICKS_GM1 - 1);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = gm_i ? LAST1 : LAST0;
    assign fire_o   = pend_q && tick_i && (cnt_q == last_idx) && !abort_i && !start_i;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (fire_o) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pend_q && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sci_mpb_capture.sv
module sci_mpb_capture (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic bit_i,
    output logic mpb_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mpb_o <= 1'b0;
        end else if (load_i) begin
            mpb_o <= bit_i;
        end
    end
endmodule

// File: rtl/sci_txend_status.sv
module sci_txend_status
    import sci_stat_pkg::*;
#(
    parameter int TICKS_GM0 = 5,
    parameter int TICKS_GM1 = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby_i,
    input  logic              sc_mode_i,
    input  logic              tx_en_i,
    input  logic              rx_en_i,
    input  logic              guard_sel_i,
    input  logic              err_sig_i,
    input  logic              half_etu_i,
    input  logic              last_bit_i,
    input  logic              tx_xfer_i,
    input  logic              mp_fmt_i,
    input  logic              mp_bit_i,
    input  logic              mp_cap_i,
    input  logic              stat_rd_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              tdre_o,
    output logic              tend_o,
    output logic              mpb_o
);
    logic      tdre_q, tend_q, mpb_q;
    logic      clr_evt, fire, force_end;
    logic      unused_wdata;
    tend_act_e tend_act;
    flags_t    flags;

    assign unused_wdata = ^stat_wdata_i;

    sci_clr_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .standby_i (standby_i),
        .rd_i      (stat_rd_i),
        .wr_i      (stat_wr_i),
        .wr_zero_i (!stat_wdata_i[TDRE_BIT]),
        .tdre_i    (tdre_q),
        .clr_o     (clr_evt)
    );

    sci_guard_timer #(
        .TICKS_GM0 (TICKS_GM0),
        .TICKS_GM1 (TICKS_GM1)
    ) u_guard (
        .clk     (clk),
        .rst     (rst),
        .abort_i (standby_i || clr_evt),
        .start_i (sc_mode_i && last_bit_i),
        .tick_i  (half_etu_i),
        .gm_i    (guard_sel_i),
        .fire_o  (fire)
    );

    sci_mpb_capture u_mpb (
        .clk    (clk),
        .rst    (rst),
        .load_i (mp_cap_i && rx_en_i && mp_fmt_i && !sc_mode_i),
        .bit_i  (mp_bit_i),
        .mpb_o  (mpb_q)
    );

    assign force_end = !tx_en_i && (!sc_mode_i || !err_sig_i);

    always_comb begin
        tend_act = TEND_HOLD;
        if (force_end) begin
            tend_act = TEND_SET;
        end else if (clr_evt) begin
            tend_act = TEND_CLEAR;
        end else if (!sc_mode_i && last_bit_i && tdre_q) begin
            tend_act = TEND_SET;
        end else if (sc_mode_i && fire && tdre_q && !err_sig_i) begin
            tend_act = TEND_SET;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || standby_i) begin
            tdre_q <= FLAGS_RESET.tdre;
            tend_q <= FLAGS_RESET.tend;
        end else begin
            if (tx_xfer_i) begin
                tdre_q <= 1'b1;
            end else if (clr_evt) begin
                tdre_q <= 1'b0;
            end
            case (tend_act)
                TEND_SET:   tend_q <= 1'b1;
                TEND_CLEAR: tend_q <= 1'b0;
                default:    tend_q <= tend_q;
            endcase
        end
    end

    assign flags  = '{mpb: mpb_q, tend: tend_q, tdre: tdre_q};
    assign stat_o = pack_status(flags);
    assign tdre_o = tdre_q;
    assign tend_o = tend_q;
    assign mpb_o  = mpb_q;

endmodule

// File: rtl/sci_txend_status_chk.sv
module sci_txend_status_chk (
    input logic clk,
    input logic rst,
    input logic standby_i,
    input logic sc_mode_i,
    input logic tx_en_i,
    input logic rx_en_i,
    input logic err_sig_i,
    input logic last_bit_i,
    input logic stat_wr_i,
    input logic clr_evt,
    input logic tdre_q,
    input logic tend_q,
    input logic mpb_q
);
    // R1
    standby_flags_chk: assert property (@(posedge clk) disable iff (rst)
        standby_i |=> (tend_q && tdre_q));

    // R3
    tx_off_forces_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_i && (!sc_mode_i || !err_sig_i)) |=> tend_q);

    // R4
    async_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!sc_mode_i && last_bit_i && tdre_q && !standby_i && !clr_evt) |=> tend_q);

    // R5
    sc_end_no_error_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tend_q) && $past(sc_mode_i) && !$past(standby_i)) |-> !$past(err_sig_i));

    // R7
    tdre_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tdre_q) |-> $past(stat_wr_i));

    // R10
    mpb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en_i |=> $stable(mpb_q));
endmodule

bind sci_txend_status sci_txend_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .standby_i  (standby_i),
    .sc_mode_i  (sc_mode_i),
    .tx_en_i    (tx_en_i),
    .rx_en_i    (rx_en_i),
    .err_sig_i  (err_sig_i),
    .last_bit_i (last_bit_i),
    .stat_wr_i  (stat_wr_i),
    .clr_evt    (clr_evt),
    .tdre_q     (tdre_q),
    .tend_q     (tend_q),
    .mpb_q      (mpb_q)
);

// File: tb/sci_txend_status_tb.sv
module sci_txend_status_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby = 0, sc_mode = 0, tx_en = 1, rx_en = 1, gsel = 0, err = 0;
    logic       tick = 0, last = 0, xfer = 0, mpfmt = 1, mpbit = 0, mpcap = 0;
    logic       rd = 0, wr = 0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] stat;
    logic       tdre_w, tend_w, mpb_w;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic m_tdre = 1, m_tend = 1, m_mpb = 0, m_arm = 0, m_pend = 0;
    int   m_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sci_txend_status u_dut (
        .clk(clk), .rst(rst), .standby_i(standby), .sc_mode_i(sc_mode),
        .tx_en_i(tx_en), .rx_en_i(rx_en), .guard_sel_i(gsel), .err_sig_i(err),
        .half_etu_i(tick), .last_bit_i(last), .tx_xfer_i(xfer), .mp_fmt_i(mpfmt),
        .mp_bit_i(mpbit), .mp_cap_i(mpcap), .stat_rd_i(rd), .stat_wr_i(wr),
        .stat_wdata_i(wdata), .stat_o(stat), .tdre_o(tdre_w), .tend_o(tend_w),
        .mpb_o(mpb_w)
    );

    function automatic logic [7:0] exp_byte(logic t, logic e, logic m);
        return {5'b0, m, e, t};
    endfunction

    // model written from the requirements R1..R10
    always @(posedge clk) begin
        logic clr, fire, tdre_o;
        int   target;
        tdre_o = m_tdre;
        target = gsel ? 2 : 5;
        clr    = wr && m_arm && !wdata[0] && !standby;
        fire   = m_pend && tick && (m_cnt == target - 1) && !standby && !clr && !(sc_mode && last);
        if (rst) begin
            m_tdre = 1; m_tend = 1; m_mpb = 0; m_arm = 0; m_pend = 0; m_cnt = 0;
        end else begin
            if (standby)  m_arm = 0;
            else if (wr)  m_arm = 0;
            else if (rd)  m_arm = tdre_o;
            if (standby || clr)        begin m_pend = 0; m_cnt = 0; end
            else if (sc_mode && last)  begin m_pend = 1; m_cnt = 0; end
            else if (fire)             begin m_pend = 0; m_cnt = 0; end
            else if (m_pend && tick)   m_cnt = m_cnt + 1;
            if (standby) begin
                m_tdre = 1; m_tend = 1;
            end else begin
                if (xfer)     m_tdre = 1;
                else if (clr) m_tdre = 0;
                if (!tx_en && (!sc_mode || !err))           m_tend = 1;
                else if (clr)                               m_tend = 0;
                else if (!sc_mode && last && tdre_o)        m_tend = 1;
                else if (sc_mode && fire && tdre_o && !err) m_tend = 1;
            end
            if (rx_en && mpfmt && !sc_mode && mpcap) m_mpb = mpbit;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        rd = 0; wr = 0; tick = 0; last = 0; xfer = 0; mpcap = 0; standby = 0;
    endtask

    task automatic do_clear();
        rd = 1; cyc();
        wr = 1; wdata = 8'h00; cyc();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst = 0;
        // R1 reset state
        chk("R1 reset", stat, exp_byte(1, 1, 0));

        // R7 unarmed write does nothing; R2 write leaves TEND
        wr = 1; wdata = 8'h00; cyc();
        chk("R7 unarmed write", stat, exp_byte(1, 1, 0));

        // R7 armed clear
        do_clear();
        chk("R7 armed clear", stat, exp_byte(0, 0, 0));

        // R2 write of ones to TEND/MPB bits ignored
        wr = 1; wdata = 8'hFF; cyc();
        chk("R2 read-only bits", stat, exp_byte(0, 0, 0));

        // R4 last bit while TDRE=0 leaves TEND
        last = 1; cyc();
        chk("R4 no set when busy", stat, exp_byte(0, 0, 0));

        // R8 transfer sets TDRE
        xfer = 1; cyc();
        chk("R8 transfer", stat, exp_byte(1, 0, 0));

        // R4 async set
        last = 1; cyc();
        chk("R4 async set", stat, exp_byte(1, 1, 0));

        // R5 smart-card, guard select 0
        sc_mode = 1; gsel = 0;
        do_clear(); xfer = 1; cyc();
        last = 1; cyc();
        ticks(4);
        chk("R5 gm0 four ticks", stat, exp_byte(1, 0, 0));
        ticks(1);
        chk("R5 gm0 fifth tick", stat, exp_byte(1, 1, 0));

        // R5 guard select 1
        gsel = 1;
        do_clear(); xfer = 1; cyc();
        last = 1; cyc();
        ticks(1);
        chk("R5 gm1 one tick", stat, exp_byte(1, 0, 0));
        ticks(1);
        chk("R5 gm1 second tick", stat, exp_byte(1, 1, 0));

        // R6 restart
        gsel = 0;
        do_clear(); xfer = 1; cyc();
        last = 1; cyc();
        ticks(3);
        last = 1; cyc();
        ticks(4);
        chk("R6 restart no early set", stat, exp_byte(1, 0, 0));
        ticks(1);
        chk("R6 restart full interval", stat, exp_byte(1, 1, 0));

        // R6 cancel by clear
        do_clear(); xfer = 1; cyc();
        last = 1; cyc();
        ticks(2);
        do_clear(); xfer = 1; cyc();
        ticks(5);
        chk("R6 cancelled interval", stat, exp_byte(1, 0, 0));

        // R5 error flag vetoes
        last = 1; err = 1; cyc();
        ticks(5);
        chk("R5 error veto", stat, exp_byte(1, 0, 0));

        // R3 smart-card: error held keeps TEND when TX off
        tx_en = 0; cyc();
        chk("R3 sc err blocks force", stat, exp_byte(1, 0, 0));
        err = 0; cyc();
        chk("R3 sc force", stat, exp_byte(1, 1, 0));
        tx_en = 1;

        // R3 async force
        sc_mode = 0;
        do_clear();
        chk("R3 pre-clear", stat, exp_byte(0, 0, 0));
        tx_en = 0; cyc();
        chk("R3 async force", stat, exp_byte(0, 1, 0));
        tx_en = 1; xfer = 1; cyc();

        // R9 capture
        mpbit = 1; mpcap = 1; cyc();
        chk("R9 capture", stat, exp_byte(1, 1, 1));
        // R10 hold while receive off
        rx_en = 0; mpbit = 0; mpcap = 1; cyc();
        chk("R10 hold", stat, exp_byte(1, 1, 1));
        rx_en = 1;
        // R9 no capture in smart-card mode
        sc_mode = 1; mpbit = 0; mpcap = 1; cyc();
        chk("R9 sc ignore", stat, exp_byte(1, 1, 1));
        // R9 no capture without multiprocessor format
        sc_mode = 0; mpfmt = 0; mpbit = 0; mpcap = 1; cyc();
        chk("R9 fmt off ignore", stat, exp_byte(1, 1, 1));
        mpfmt = 1;

        // R1 standby sets flags, keeps MPB
        do_clear();
        chk("R1 pre-standby", stat, exp_byte(0, 0, 1));
        standby = 1; cyc();
        chk("R1 standby", stat, exp_byte(1, 1, 1));

        // R7 read seeing TDRE=0 disarms
        do_clear();
        rd = 1; cyc();
        xfer = 1; cyc();
        wr = 1; wdata = 8'h00; cyc();
        chk("R7 disarmed by read of 0", stat, exp_byte(1, 0, 1));

        // random traffic compared against the model
        void'($urandom(32'h5c1f_0042));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk("R2 random vs model", stat, exp_byte(m_tdre, m_tend, m_mpb));
            rst     = ($urandom % 400) == 0;
            standby = ($urandom % 150) == 0;
            if (($urandom % 60) == 0) sc_mode = ~sc_mode;
            if (($urandom % 40) == 0) gsel = ~gsel;
            tx_en   = ($urandom % 12) != 0;
            rx_en   = ($urandom % 5) != 0;
            err     = ($urandom % 10) == 0;
            tick    = ($urandom % 3) == 0;
            last    = ($urandom % 12) == 0;
            xfer    = ($urandom % 10) == 0;
            mpfmt   = ($urandom % 5) != 0;
            mpbit   = 1'($urandom);
            mpcap   = ($urandom % 5) == 0;
            rd      = ($urandom % 3) == 0;
            wr      = ($urandom % 5) == 0;
            wdata   = 8'($urandom);
        end
        @(negedge clk);
        chk("R1 random end", stat, exp_byte(m_tdre, m_tend, m_mpb));

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule